// File: doc/BRIEF.md
# Priority Interrupt Acceptance Controller

This block sits between a processor core and its interrupt sources and decides, cycle by cycle, whether a request is taken at once or parked for later. Requests come from four dedicated pins and from a message port that carries a vector and a priority off the data bus. Each pin has its own programmable vector and priority. A request is taken only when its priority is strictly above the priority of the task the core is running. The vector of a taken request is then presented to the core as an index into its interrupt table.

A request that does not win is never dropped. It goes into a pending store that holds one bit per priority level and one vector per level. The controller looks at the store every cycle. When the core lowers its task priority, or acknowledges the interrupt it holds, the highest pending level that now beats the task priority is dispatched and removed from the store. Only one interrupt is outstanding at a time. It stays on the outputs until the core acknowledges it.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A synchronous active-high reset drops `irq_valid`, empties the pending store and sets every pin's vector and priority to zero.
- R2: A request with priority strictly greater than `task_prio`, arriving while no interrupt is outstanding, raises `irq_valid` after the next rising clock edge, with its vector on `irq_vec` and its priority on `irq_prio`.
- R3: A request is kept in the pending store and not lost when its priority is equal to or below `task_prio`, or when an interrupt is outstanding. This includes a request that arrives in the same cycle as `irq_ack`.
- R4: An outstanding interrupt holds `irq_valid`, `irq_vec` and `irq_prio` steady until `irq_ack` is high at a clock edge, and `irq_valid` is low after that edge. `irq_ack` while `irq_valid` is low has no effect.
- R5: Whenever no interrupt is outstanding, the highest pending level above `task_prio` is dispatched at the next edge and cleared from the store. This includes the edge after `task_prio` is lowered.
- R6: A pin raises a request only in a cycle where it is high and was low in the previous cycle. A pin held high does not raise a second request.
- R7: With `cfg_we` high, `cfg_vec` and `cfg_prio` are written to the pin selected by `cfg_sel`. The new values apply to pin edges from the next cycle on. An edge in the write cycle uses the old values.
- R8: When several requests compete in one cycle, the highest priority among the new and pending requests is served first. The rest are kept pending.
- R9: Requests at the same priority level in the same cycle share one store entry. The message port's vector wins over any pin's, and a lower-numbered pin wins over a higher-numbered one.
- R10: A new request at a level that is already pending replaces the stored vector for that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req | input | 4 | Interrupt request pins, edge sensitive |
| cfg_we | input | 1 | Write enable for a pin's vector and priority |
| cfg_sel | input | 2 | Pin index for the configuration write |
| cfg_vec | input | 8 | Vector to store for the selected pin |
| cfg_prio | input | 5 | Priority to store for the selected pin |
| msg_valid | input | 1 | Interrupt message present this cycle |
| msg_vec | input | 8 | Vector carried by the message |
| msg_prio | input | 5 | Priority carried by the message |
| task_prio | input | 5 | Priority of the currently running task |
| irq_valid | output | 1 | Accepted interrupt outstanding |
| irq_vec | output | 8 | Interrupt table index of the accepted interrupt |
| irq_prio | output | 5 | Priority of the accepted interrupt |
| irq_ack | input | 1 | Core acknowledges the outstanding interrupt |

## Verification
The bench sends a request at exactly the task priority. A design that compares with greater-or-equal would accept it at once instead of holding it until the task priority drops. It sends a message and a pin edge together, and two pins at one level together. A wrong arbiter would show the lower priority first, or the wrong pin's vector, or a second dispatch at a level that holds only one entry. It also sends a request in the same cycle as an acknowledge, writes a pin's configuration in the cycle that pin rises, and keeps a pin held high. A design that loses the request, applies the new configuration early, or fires on a level instead of an edge gives a different vector or an extra interrupt. A reset with a pending entry shows whether the store is really cleared: a leftover entry would be dispatched once the task priority is lowered to zero.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int unsigned DEF_NUM_PINS = 4;
  localparam int unsigned DEF_PRIO_W   = 5;
  localparam int unsigned DEF_VEC_W    = 8;
endpackage

// File: rtl/irq_prio_enc.sv
// Highest-set-bit encoder over the merged request bitmap.
module irq_prio_enc #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] bits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pin_frontend.sv
// Per-pin configuration registers and rising-edge detection.
module irq_pin_frontend #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned PRIO_W   = 5,
  parameter int unsigned VEC_W    = 8,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PINS-1:0]             pin_req,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [VEC_W-1:0]                cfg_vec,
  input  logic [PRIO_W-1:0]               cfg_prio,
  output logic [NUM_PINS-1:0]             edge_hit,
  output logic [NUM_PINS-1:0][VEC_W-1:0]  pin_vec,
  output logic [NUM_PINS-1:0][PRIO_W-1:0] pin_prio
);
  logic [NUM_PINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_req;
  end

  assign edge_hit = pin_req & ~pin_q;

  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_vec[p]  <= '0;
        pin_prio[p] <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(p)) begin
        pin_vec[p]  <= cfg_vec;
        pin_prio[p] <= cfg_prio;
      end
    end
  end
endmodule

// File: rtl/irq_level_map.sv
// Folds the new requests of one cycle onto priority levels.
// Source 0 has the highest precedence when two sources share a level.
module irq_level_map #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned NLVL   = 1 << PRIO_W
) (
  input  logic [NUM_SRC-1:0]             src_hit,
  input  logic [NUM_SRC-1:0][VEC_W-1:0]  src_vec,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
  output logic [NLVL-1:0]                lvl_hit,
  output logic [NLVL-1:0][VEC_W-1:0]     lvl_vec
);
  for (genvar l = 0; l < int'(NLVL); l++) begin : g_lvl
    logic             hit_l;
    logic [VEC_W-1:0] vec_l;
    always_comb begin
      hit_l = 1'b0;
      vec_l = '0;
      for (int s = int'(NUM_SRC) - 1; s >= 0; s--) begin
        if (src_hit[s] && src_prio[s] == PRIO_W'(l)) begin
          hit_l = 1'b1;
          vec_l = src_vec[s];
        end
      end
    end
    assign lvl_hit[l] = hit_l;
    assign lvl_vec[l] = vec_l;
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int unsigned NUM_PINS = DEF_NUM_PINS,
  parameter int unsigned PRIO_W   = DEF_PRIO_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_req,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [VEC_W-1:0]    cfg_vec,
  input  logic [PRIO_W-1:0]   cfg_prio,
  input  logic                msg_valid,
  input  logic [VEC_W-1:0]    msg_vec,
  input  logic [PRIO_W-1:0]   msg_prio,
  input  logic [PRIO_W-1:0]   task_prio,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vec,
  output logic [PRIO_W-1:0]   irq_prio,
  input  logic                irq_ack
);
  localparam int unsigned NLVL = 1 << PRIO_W;
  localparam int unsigned NSRC = NUM_PINS + 1;

  // Pin front end
  logic [NUM_PINS-1:0]             edge_hit;
  logic [NUM_PINS-1:0][VEC_W-1:0]  pin_vec;
  logic [NUM_PINS-1:0][PRIO_W-1:0] pin_prio;

  irq_pin_frontend #(
    .NUM_PINS(NUM_PINS), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_pins (
    .clk(clk), .rst(rst), .pin_req(pin_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec), .cfg_prio(cfg_prio),
    .edge_hit(edge_hit), .pin_vec(pin_vec), .pin_prio(pin_prio)
  );

  // Source list: message first (highest precedence on a shared level), then pins by index
  logic [NSRC-1:0]             src_hit;
  logic [NSRC-1:0][VEC_W-1:0]  src_vec;
  logic [NSRC-1:0][PRIO_W-1:0] src_prio;

  assign src_hit[0]  = msg_valid;
  assign src_vec[0]  = msg_vec;
  assign src_prio[0] = msg_prio;
  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_src
    assign src_hit[p+1]  = edge_hit[p];
    assign src_vec[p+1]  = pin_vec[p];
    assign src_prio[p+1] = pin_prio[p];
  end

  logic [NLVL-1:0]            new_hit;
  logic [NLVL-1:0][VEC_W-1:0] new_vec;

  irq_level_map #(
    .NUM_SRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_map (
    .src_hit(src_hit), .src_vec(src_vec), .src_prio(src_prio),
    .lvl_hit(new_hit), .lvl_vec(new_vec)
  );

  // Pending store: one bit and one vector per level
  logic [NLVL-1:0]  pend_bits;
  logic [VEC_W-1:0] pend_vec [NLVL];

  for (genvar l = 0; l < int'(NLVL); l++) begin : g_store
    always_ff @(posedge clk) begin
      if (new_hit[l]) pend_vec[l] <= new_vec[l];
    end
  end

  // Arbitration over pending and new requests
  logic [NLVL-1:0]   merged;
  logic              sel_any;
  logic [PRIO_W-1:0] sel_lvl;
  logic [VEC_W-1:0]  sel_vec;
  logic              take;
  logic [NLVL-1:0]   take_mask;

  assign merged = pend_bits | new_hit;

  irq_prio_enc #(.WIDTH(NLVL)) u_enc (
    .bits(merged), .any(sel_any), .idx(sel_lvl)
  );

  assign sel_vec   = new_hit[sel_lvl] ? new_vec[sel_lvl] : pend_vec[sel_lvl];
  assign take      = sel_any && !irq_valid && (sel_lvl > task_prio);
  assign take_mask = take ? (NLVL'(1) << sel_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_bits <= '0;
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_prio  <= '0;
    end else begin
      pend_bits <= merged & ~take_mask;
      if (irq_valid && irq_ack) begin
        irq_valid <= 1'b0;
      end else if (take) begin
        irq_valid <= 1'b1;
        irq_vec   <= sel_vec;
        irq_prio  <= sel_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int unsigned PRIO_W = 5,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              msg_valid,
  input logic [PRIO_W-1:0] msg_prio,
  input logic [PRIO_W-1:0] task_prio,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [PRIO_W-1:0] irq_prio,
  input logic              irq_ack
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !irq_valid);

  // R2
  a_r2_above_task: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> irq_prio > $past(task_prio));

  // R2, R8
  a_r2_msg_taken: assert property (@(posedge clk) disable iff (rst)
    (!irq_valid && msg_valid && msg_prio > task_prio)
      |=> (irq_valid && irq_prio >= $past(msg_prio)));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vec) && $stable(irq_prio)));

  // R4
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack) |=> !irq_valid);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_prio(msg_prio),
  .task_prio(task_prio), .irq_valid(irq_valid), .irq_vec(irq_vec),
  .irq_prio(irq_prio), .irq_ack(irq_ack)
);

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pin_req;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_vec;
  logic [4:0] cfg_prio;
  logic       msg_valid;
  logic [7:0] msg_vec;
  logic [4:0] msg_prio;
  logic [4:0] task_prio;
  logic       irq_valid;
  logic [7:0] irq_vec;
  logic [4:0] irq_prio;
  logic       irq_ack;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_accept_ctrl i_irq_accept_ctrl (
    .clk(clk), .rst(rst), .pin_req(pin_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec), .cfg_prio(cfg_prio),
    .msg_valid(msg_valid), .msg_vec(msg_vec), .msg_prio(msg_prio),
    .task_prio(task_prio), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .irq_prio(irq_prio), .irq_ack(irq_ack)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] tp;
    logic       mv;
    logic [4:0] mp;
    logic [7:0] mvec;
    logic [3:0] pins;
    logic       ack;
    logic       ev;
    logic [7:0] evec;
    logic [4:0] ep;
  } step_t;

  localparam int NSTEP = 30;
  // Pin setup before the table: pin0 0x40/10, pin1 0x41/20, pin2 0x42/3, pin3 0x43/20
  localparam step_t TBL [NSTEP] = '{
    '{4'd2,  5'd5,  1'b1, 5'd9,  8'h99, 4'b0000, 1'b0, 1'b1, 8'h99, 5'd9 },  // R2 accept above task
    '{4'd4,  5'd5,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'h99, 5'd9 },  // R4 held
    '{4'd3,  5'd5,  1'b1, 5'd12, 8'hAA, 4'b0000, 1'b0, 1'b1, 8'h99, 5'd9 },  // R3 busy -> pending
    '{4'd4,  5'd5,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },  // R4 ack clears
    '{4'd5,  5'd5,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'hAA, 5'd12},  // R5 pending dispatched
    '{4'd4,  5'd5,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd3,  5'd5,  1'b1, 5'd5,  8'h55, 4'b0000, 1'b0, 1'b0, 8'h00, 5'd0 },  // R3 equal prio waits
    '{4'd5,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'h55, 5'd5 },  // R5 task drop
    '{4'd4,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd8,  5'd4,  1'b1, 5'd7,  8'h77, 4'b0001, 1'b0, 1'b1, 8'h40, 5'd10},  // R8 pin beats msg
    '{4'd6,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0001, 1'b1, 1'b0, 8'h00, 5'd0 },  // R6 held pin
    '{4'd8,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0001, 1'b0, 1'b1, 8'h77, 5'd7 },  // R8 loser served next
    '{4'd4,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd9,  5'd4,  1'b0, 5'd0,  8'h00, 4'b1010, 1'b0, 1'b1, 8'h41, 5'd20},  // R9 lower pin wins
    '{4'd4,  5'd4,  1'b0, 5'd0,  8'h00, 4'b1010, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd9,  5'd4,  1'b0, 5'd0,  8'h00, 4'b1010, 1'b0, 1'b0, 8'h00, 5'd0 },  // R9 one entry, R6 no retrigger
    '{4'd6,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b0, 8'h00, 5'd0 },
    '{4'd3,  5'd4,  1'b0, 5'd0,  8'h00, 4'b0100, 1'b0, 1'b0, 8'h00, 5'd0 },  // R3 pin below task
    '{4'd10, 5'd4,  1'b1, 5'd3,  8'h33, 4'b0100, 1'b0, 1'b0, 8'h00, 5'd0 },  // R10 overwrite vector
    '{4'd10, 5'd2,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'h33, 5'd3 },  // R10 newer vector out
    '{4'd4,  5'd31, 1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd3,  5'd31, 1'b1, 5'd31, 8'hF1, 4'b0000, 1'b0, 1'b0, 8'h00, 5'd0 },  // R3 top level equal
    '{4'd5,  5'd30, 1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'hF1, 5'd31},  // R5
    '{4'd4,  5'd30, 1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },
    '{4'd4,  5'd30, 1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },  // R4 idle ack no effect
    '{4'd3,  5'd0,  1'b1, 5'd0,  8'h01, 4'b0000, 1'b0, 1'b0, 8'h00, 5'd0 },  // R3 level 0 never wins
    '{4'd2,  5'd0,  1'b1, 5'd6,  8'h66, 4'b0000, 1'b0, 1'b1, 8'h66, 5'd6 },  // R2
    '{4'd3,  5'd0,  1'b1, 5'd8,  8'h88, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 },  // R3 request with ack
    '{4'd3,  5'd0,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b0, 1'b1, 8'h88, 5'd8 },  // R3 not lost
    '{4'd4,  5'd0,  1'b0, 5'd0,  8'h00, 4'b0000, 1'b1, 1'b0, 8'h00, 5'd0 }
  };

  task automatic drive(input logic [4:0] tp, input logic mv, input logic [4:0] mp,
                       input logic [7:0] mvec, input logic [3:0] pins, input logic ack);
    @(negedge clk);
    task_prio = tp;
    msg_valid = mv;
    msg_prio  = mp;
    msg_vec   = mvec;
    pin_req   = pins;
    irq_ack   = ack;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ev, input logic [7:0] evec,
                       input logic [4:0] ep);
    checks++;
    if (irq_valid !== ev || (ev && (irq_vec !== evec || irq_prio !== ep))) begin
      fails++;
      $display("FAIL %s: actual valid=%0b vec=%02h prio=%0d expected valid=%0b vec=%02h prio=%0d",
               tag, irq_valid, irq_vec, irq_prio, ev, evec, ep);
    end
  endtask

  task automatic cfg_pin(input logic [1:0] sel, input logic [7:0] v, input logic [4:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_vec = v; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; pin_req = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_vec = '0; cfg_prio = '0;
    msg_valid = 1'b0; msg_vec = '0; msg_prio = '0; task_prio = '0; irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 1'b0, 8'h00, 5'd0);
    @(negedge clk);
    rst = 1'b0;

    cfg_pin(2'd0, 8'h40, 5'd10);
    cfg_pin(2'd1, 8'h41, 5'd20);
    cfg_pin(2'd2, 8'h42, 5'd3);
    cfg_pin(2'd3, 8'h43, 5'd20);

    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i].tp, TBL[i].mv, TBL[i].mp, TBL[i].mvec, TBL[i].pins, TBL[i].ack);
      check($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].ev, TBL[i].evec, TBL[i].ep);
    end

    // R1: reset with an entry pending empties the store
    drive(5'd31, 1'b1, 5'd20, 8'hC0, 4'b0000, 1'b0);
    check("R3 parked before reset", 1'b0, 8'h00, 5'd0);
    @(negedge clk);
    rst = 1'b1; msg_valid = 1'b0; task_prio = 5'd0;
    @(posedge clk);
    #1;
    check("R1 valid low in reset", 1'b0, 8'h00, 5'd0);
    @(negedge clk);
    rst = 1'b0;
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0000, 1'b0);
    check("R1 pending cleared", 1'b0, 8'h00, 5'd0);

    // R1: pin configuration back to priority 0, cannot beat task 0
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0001, 1'b0);
    check("R1 pin config cleared", 1'b0, 8'h00, 5'd0);

    // R7: write in the edge cycle uses old settings; next edge uses new
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_vec = 8'h5A; cfg_prio = 5'd15;
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0100, 1'b0);
    cfg_we = 1'b0;
    check("R7 old config in write cycle", 1'b0, 8'h00, 5'd0);
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0000, 1'b0);
    check("R6 falling edge no request", 1'b0, 8'h00, 5'd0);
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0100, 1'b0);
    check("R7 new config applied", 1'b1, 8'h5A, 5'd15);
    drive(5'd0, 1'b0, 5'd0, 8'h00, 4'b0000, 1'b1);
    check("R4 ack after config test", 1'b0, 8'h00, 5'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule